// File: doc/BRIEF.md
# DS3 M13 Transmit Overhead Inserter

This block produces the outbound serial DS3 M-frame for M13/M23 operation, one line bit per clock. An upstream source supplies payload bits one per clock whenever the block raises its payload request. The block places each of these bits into the 4760-bit M-frame and generates every overhead position itself. These positions are the framing bits, the multiframe alignment bits, the parity pair, the stuff-indicator C-bits and the remote-alarm X-bits.

When the external overhead enable is high, the upstream source may also supply the X-bit and C-bit values. It presents each such value on the same data input during the slot that the overhead strobe marks, and that value replaces the internal one. The framing, alignment and parity positions ignore the enable and are always generated internally. The X-bits normally follow a software value, but they are forced low whenever the receive side reports loss of signal, loss of frame or an alarm indication signal.

Top module: `ds3_ohins_top`

## Requirements
- R1: A frame is 4760 slots: 7 subframes, each of 8 blocks, each block being one overhead slot followed by 84 payload slots. After reset the first slot is frame position 0. `out_sof` is high exactly while `out_bit` carries frame position 0.
- R2: `oh_strobe` is high exactly in the overhead slot of each block and `pay_req` is high exactly in the other slots. The bit for the slot presented in one clock appears on `out_bit` in the following clock.
- R3: The overhead slots of blocks 1 to 7 of every subframe (blocks numbered 0 to 7) carry F1, C, F0, C, F0, C, F1 in that order. An F1 slot is 1 and an F0 slot is 0.
- R4: Block 0 of subframes 5, 6 and 7 (subframes numbered 1 to 7) carries the alignment bits 0, 1, 0.
- R5: Block 0 of subframes 1 and 2 is an X-bit. With the enable low, it equals `sw_xbit` when no defect input is high, and it is 0 when any of `rx_los`, `rx_lof` or `rx_ais` is high.
- R6: With the enable low, every C slot is 0.
- R7: Every payload slot carries the `in_bit` value presented in that slot, unchanged.
- R8: With `ext_oh_en` high, X and C slots carry the `in_bit` value presented in that slot.
- R9: `ext_oh_en` and the `in_bit` value presented in F, M and P slots have no effect on those slots.
- R10: Block 0 of subframes 3 and 4 is a P-bit. Both P-bits of a frame equal the XOR of all 4704 payload bits of the previous frame. In the first frame after reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_oh_en | input | 1 | Take X and C values from `in_bit` |
| sw_xbit | input | 1 | Software value for the X-bits |
| rx_los | input | 1 | Receive loss-of-signal defect |
| rx_lof | input | 1 | Receive loss/out-of-frame defect |
| rx_ais | input | 1 | Receive alarm indication defect |
| in_bit | input | 1 | Payload bit, or an override value in overhead slots |
| oh_strobe | output | 1 | Current slot is an overhead slot |
| pay_req | output | 1 | Current slot is a payload slot |
| out_bit | output | 1 | Serial line bit, one clock after its slot |
| out_sof | output | 1 | `out_bit` is frame position 0 |

## Verification
The assertions assume that the upstream source answers each slot in the same clock. `in_bit`, the enable, the software value and the defect inputs are taken as already settled for the slot at the edge that closes it, and no other handshake is assumed. The stimulus changes all inputs only at falling edges. It redraws the defects and the software X value per slot from a seeded random source, and it switches the enable only at frame boundaries. One directed frame drives the complement of the correct value into every F, M and P slot while the enable is high, and it uses an all-ones payload so that the next frame's parity is known.

// File: rtl/ds3_ohins_pkg.sv
package ds3_ohins_pkg;

   localparam int          SUBFRAMES = 7;
   localparam int          BLOCKS    = 8;
   localparam logic [2:0]  LAST_SUB  = 3'(SUBFRAMES - 1);
   localparam logic [2:0]  LAST_BLK  = 3'(BLOCKS - 1);

   typedef enum logic [2:0] {
      K_PAY, K_X, K_P, K_M0, K_M1, K_F0, K_F1, K_C
   } slot_kind_e;

   // Kind of the overhead slot in block blk of subframe sub (both from 0).
   function automatic slot_kind_e oh_kind(input logic [2:0] sub, input logic [2:0] blk);
      slot_kind_e k;
      if (blk == 3'd0) begin
         case (sub)
            3'd0, 3'd1: k = K_X;
            3'd2, 3'd3: k = K_P;
            3'd5:       k = K_M1;
            default:    k = K_M0;
         endcase
      end else begin
         case (blk)
            3'd1, 3'd7: k = K_F1;
            3'd3, 3'd5: k = K_F0;
            default:    k = K_C;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/ds3_ohins_seq.sv
module ds3_ohins_seq
   import ds3_ohins_pkg::*;
#(
   parameter int PAY_BITS = 84,
   localparam int BIT_W   = $clog2(PAY_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [BIT_W-1:0] bit_pos,
   output logic [2:0]       blk,
   output logic [2:0]       sub,
   output logic             frame_first,
   output logic             frame_last
);

   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PAY_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_pos <= '0;
         blk     <= '0;
         sub     <= '0;
      end else if (bit_pos == LAST_BIT) begin
         bit_pos <= '0;
         if (blk == LAST_BLK) begin
            blk <= '0;
            sub <= (sub == LAST_SUB) ? 3'd0 : sub + 3'd1;
         end else begin
            blk <= blk + 3'd1;
         end
      end else begin
         bit_pos <= bit_pos + 1'b1;
      end
   end

   assign frame_first = (bit_pos == '0) && (blk == '0) && (sub == '0);
   assign frame_last  = (bit_pos == LAST_BIT) && (blk == LAST_BLK) && (sub == LAST_SUB);

endmodule

// File: rtl/ds3_ohins_parity.sv
module ds3_ohins_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic pay_valid,
   input  logic pay_bit,
   input  logic frame_last,
   output logic p_bit
);

   logic acc;
   logic held;
   logic contrib;

   assign contrib = pay_valid & pay_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= 1'b0;
         held <= 1'b0;
      end else if (frame_last) begin
         held <= acc ^ contrib;
         acc  <= 1'b0;
      end else begin
         acc  <= acc ^ contrib;
      end
   end

   assign p_bit = held;

endmodule

// File: rtl/ds3_ohins_mux.sv
module ds3_ohins_mux
   import ds3_ohins_pkg::*;
(
   input  slot_kind_e kind,
   input  logic       in_bit,
   input  logic       ext_oh_en,
   input  logic       x_int,
   input  logic       p_bit,
   output logic       line_bit
);

   always_comb begin
      case (kind)
         K_PAY:       line_bit = in_bit;
         K_X:         line_bit = ext_oh_en ? in_bit : x_int;
         K_C:         line_bit = ext_oh_en & in_bit;
         K_P:         line_bit = p_bit;
         K_M1, K_F1:  line_bit = 1'b1;
         default:     line_bit = 1'b0;
      endcase
   end

endmodule

// File: rtl/ds3_ohins_top.sv
module ds3_ohins_top
   import ds3_ohins_pkg::*;
#(
   parameter int PAY_BITS = 84
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_oh_en,
   input  logic sw_xbit,
   input  logic rx_los,
   input  logic rx_lof,
   input  logic rx_ais,
   input  logic in_bit,
   output logic oh_strobe,
   output logic pay_req,
   output logic out_bit,
   output logic out_sof
);

   localparam int BIT_W = $clog2(PAY_BITS + 1);

   if (PAY_BITS < 2) begin : g_bad_pay
      $error("ds3_ohins_top: PAY_BITS must be at least 2");
   end

   logic [BIT_W-1:0] bit_pos;
   logic [2:0]       blk;
   logic [2:0]       sub;
   logic             frame_first;
   logic             frame_last;
   logic             p_bit;
   logic             x_int;
   logic             line_bit;
   slot_kind_e       kind;

   ds3_ohins_seq #(.PAY_BITS(PAY_BITS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_pos     (bit_pos),
      .blk         (blk),
      .sub         (sub),
      .frame_first (frame_first),
      .frame_last  (frame_last)
   );

   assign oh_strobe = (bit_pos == '0);
   assign pay_req   = ~oh_strobe;
   assign kind      = oh_strobe ? oh_kind(sub, blk) : K_PAY;
   assign x_int     = sw_xbit & ~(rx_los | rx_lof | rx_ais);

   ds3_ohins_parity u_par (
      .clk        (clk),
      .rst_n      (rst_n),
      .pay_valid  (pay_req),
      .pay_bit    (in_bit),
      .frame_last (frame_last),
      .p_bit      (p_bit)
   );

   ds3_ohins_mux u_mux (
      .kind      (kind),
      .in_bit    (in_bit),
      .ext_oh_en (ext_oh_en),
      .x_int     (x_int),
      .p_bit     (p_bit),
      .line_bit  (line_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bit <= 1'b0;
         out_sof <= 1'b0;
      end else begin
         out_bit <= line_bit;
         out_sof <= frame_first;
      end
   end

endmodule

// File: rtl/ds3_ohins_checker.sv
module ds3_ohins_checker
   import ds3_ohins_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic ext_oh_en,
   input logic sw_xbit,
   input logic rx_los,
   input logic rx_lof,
   input logic rx_ais,
   input logic in_bit,
   input logic oh_strobe,
   input logic pay_req,
   input logic out_bit,
   input logic out_sof
);

   // Own position tracker, advanced by the overhead strobe only.
   logic [2:0] c_blk;
   logic [2:0] c_sub;
   slot_kind_e c_kind;
   logic       defect;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_blk <= '0;
         c_sub <= '0;
      end else if (oh_strobe) begin
         if (c_blk == LAST_BLK) begin
            c_blk <= '0;
            c_sub <= (c_sub == LAST_SUB) ? 3'd0 : c_sub + 3'd1;
         end else begin
            c_blk <= c_blk + 3'd1;
         end
      end
   end

   assign c_kind = oh_kind(c_sub, c_blk);
   assign defect = rx_los | rx_lof | rx_ais;

   // R2: overhead strobe never lasts two slots
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      oh_strobe |=> !oh_strobe);

   // R1: frame marker follows frame position 0 only
   a_r1_sof_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && c_sub == 3'd0 && c_blk == 3'd0) |=> out_sof);
   a_r1_sof_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !oh_strobe |=> !out_sof);

   // R3 R4 R9: fixed framing values regardless of override
   a_r3_fixed_one: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && (c_kind == K_F1 || c_kind == K_M1)) |=> out_bit);
   a_r4_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && (c_kind == K_F0 || c_kind == K_M0)) |=> !out_bit);

   // R5: internal X-bit
   a_r5_x_defect: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && c_kind == K_X && !ext_oh_en && defect) |=> !out_bit);
   a_r5_x_soft: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && c_kind == K_X && !ext_oh_en && !defect) |=> (out_bit == $past(sw_xbit)));

   // R6: internal C-bit
   a_r6_c_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && c_kind == K_C && !ext_oh_en) |=> !out_bit);

   // R7: payload passes through
   a_r7_payload: assert property (@(posedge clk) disable iff (!rst_n)
      pay_req |=> (out_bit == $past(in_bit)));

   // R8: override of X and C
   a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_strobe && ext_oh_en && (c_kind == K_X || c_kind == K_C)) |=> (out_bit == $past(in_bit)));

endmodule

bind ds3_ohins_top ds3_ohins_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_oh_en (ext_oh_en),
   .sw_xbit   (sw_xbit),
   .rx_los    (rx_los),
   .rx_lof    (rx_lof),
   .rx_ais    (rx_ais),
   .in_bit    (in_bit),
   .oh_strobe (oh_strobe),
   .pay_req   (pay_req),
   .out_bit   (out_bit),
   .out_sof   (out_sof)
);

// File: tb/sim_ds3_ohins_top.sv
`timescale 1ns/1ps
module sim_ds3_ohins_top;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, ext_oh_en, sw_xbit, rx_los, rx_lof, rx_ais, in_bit;
   logic oh_strobe, pay_req, out_bit, out_sof;

   ds3_ohins_top u0 (
      .clk (clk), .rst_n (rst_n), .ext_oh_en (ext_oh_en), .sw_xbit (sw_xbit),
      .rx_los (rx_los), .rx_lof (rx_lof), .rx_ais (rx_ais), .in_bit (in_bit),
      .oh_strobe (oh_strobe), .pay_req (pay_req), .out_bit (out_bit), .out_sof (out_sof)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam int KPAY = 0, KX = 1, KP = 2, KM0 = 3, KM1 = 4, KF0 = 5, KF1 = 6, KC = 7;

   function automatic int kind_of(int s, int b, int p);
      if (p != 0) return KPAY;
      if (b == 0) begin
         case (s)
            0, 1:    return KX;
            2, 3:    return KP;
            5:       return KM1;
            default: return KM0;
         endcase
      end
      case (b)
         1, 7:    return KF1;
         3, 5:    return KF0;
         default: return KC;
      endcase
   endfunction

   function automatic bit exp_of(int k, bit inb, bit ext, bit sw, bit def, bit par);
      case (k)
         KPAY:     return inb;
         KX:       return ext ? inb : (sw & ~def);
         KC:       return ext ? inb : 1'b0;
         KP:       return par;
         KM1, KF1: return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(int k, bit ext);
      if (ext && (k == KX || k == KC)) return "R8";
      if (ext && k != KPAY)            return "R9";
      case (k)
         KPAY:     return "R7";
         KX:       return "R5";
         KP:       return "R10";
         KM0, KM1: return "R4";
         KF0, KF1: return "R3";
         default:  return "R6";
      endcase
   endfunction

   task automatic check(input bit got, input bit exp, input string tag, input string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: got=%0b exp=%0b", tag, what, got, exp);
      end
   endtask

   initial begin
      int    k;
      bit    e, ext, sw, def, inb, par_prev, acc, pexp, psof, pvalid;
      string ptag;
      void'($urandom(32'd7341));
      rst_n = 1'b0; ext_oh_en = 1'b0; sw_xbit = 1'b1;
      rx_los = 1'b0; rx_lof = 1'b0; rx_ais = 1'b0; in_bit = 1'b0;
      repeat (3) @(negedge clk);
      check(out_bit, 1'b0, "R1", "reset line bit");
      check(out_sof, 1'b0, "R1", "reset frame marker");
      rst_n = 1'b1;
      par_prev = 1'b0; acc = 1'b0; pvalid = 1'b0; pexp = 1'b0; psof = 1'b0; ptag = "";
      for (int f = 0; f < 5; f++) begin
         for (int s = 0; s < 7; s++) begin
            for (int b = 0; b < 8; b++) begin
               for (int p = 0; p <= 84; p++) begin
                  if (pvalid) begin
                     check(out_bit, pexp, ptag, "line bit");
                     check(out_sof, psof, "R1", "frame marker");
                  end
                  check(oh_strobe, p == 0, "R2", "overhead strobe");
                  check(pay_req, p != 0, "R2", "payload request");
                  k   = kind_of(s, b, p);
                  ext = (f == 2 || f == 3);
                  if (f == 0) begin
                     sw = 1'b1; rx_los = 1'b0; rx_lof = 1'b0; rx_ais = 1'b0;
                  end else begin
                     sw     = 1'($urandom % 2);
                     rx_los = (($urandom % 4) == 0);
                     rx_lof = (($urandom % 4) == 0);
                     rx_ais = (($urandom % 4) == 0);
                  end
                  def = rx_los | rx_lof | rx_ais;
                  if (f == 3 && k == KPAY)
                     inb = 1'b1;
                  else if (f == 3 && k != KX && k != KC)
                     inb = ~exp_of(k, 1'b0, 1'b0, 1'b0, 1'b0, par_prev);
                  else
                     inb = 1'($urandom % 2);
                  ext_oh_en = ext; sw_xbit = sw; in_bit = inb;
                  e = exp_of(k, inb, ext, sw, def, par_prev);
                  if (k == KPAY) acc = acc ^ inb;
                  if (s == 6 && b == 7 && p == 84) begin
                     par_prev = acc;
                     acc = 1'b0;
                  end
                  pexp = e; ptag = tag_of(k, ext);
                  psof = (s == 0 && b == 0 && p == 0);
                  pvalid = 1'b1;
                  @(negedge clk);
               end
            end
         end
      end
      check(out_bit, pexp, ptag, "final line bit");
      check(out_sof, psof, "R1", "final frame marker");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R1 watchdog: got=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule